// File: doc/BRIEF.md
# Instruction Fetch Cache with Clear and Dump Sequencers

This block is a direct-mapped instruction cache that sits between a CPU fetch port and a 16-bit external memory bus. It holds 1 KB as 128 lines of 8 bytes. Each line is addressed by byte-address bits 9:3, the word within the line by bit 2, and the tag is bits 31:10. The CPU asks for 32-bit words through a request/acknowledge port that carries a word address. The cache answers hits in the same cycle. On a miss it refills the whole line from memory. A line that is refilled is always overwritten, so the cache keeps following the code stream and never freezes once it is full.

Software drives the cache through a control word. Bit 1 is the enable flag. Bit 0 starts a clear pass that invalidates every entry. Bit 4 starts a dump that writes every entry, tag word and data, to memory. Bits 31:8 of the same word give the dump base address, and its low 8 bits are zero. While the cache is disabled, fetches bypass it and go straight to memory. An input selects wait states: with it set, every 16-bit bus access takes two cycles instead of one.

The controller has six states:
- `ST_IDLE` serves hits and accepts control writes.
- `ST_FILL` reads a line.
- `ST_BYPASS` reads one uncached word.
- `ST_REPLY` returns the word after a fill or a bypass.
- `ST_WIPE` clears one entry per cycle.
- `ST_DUMP` writes entries to memory.

The transitions are:
- `ST_IDLE` goes to `ST_WIPE` on a control write with bit 0 set.
- `ST_IDLE` goes to `ST_DUMP` on a control write with bit 4 set and bit 0 clear.
- `ST_IDLE` goes to `ST_BYPASS` on a fetch while disabled.
- `ST_IDLE` goes to `ST_FILL` on an enabled miss.
- `ST_FILL` goes to `ST_REPLY` after its fourth halfword.
- `ST_BYPASS` goes to `ST_REPLY` after its second halfword.
- `ST_REPLY` goes to `ST_IDLE`.
- `ST_WIPE` goes to `ST_IDLE` after the last entry.
- `ST_DUMP` goes to `ST_IDLE` after the last halfword of the last entry.

Top module: `fetch_cache`

## Requirements
- R1: After reset the cache is disabled, every entry is invalid, `f_ack` is low and `m_req` is low. The first fetch therefore takes the uncached path.
- R2: A control write is taken only in `ST_IDLE` and always loads the enable flag from bit 1 and the base from bits 31:8. Bit 0 (clear) wins over bit 4 (dump): when both are set only the clear pass runs and no bus write is issued.
- R3: An enabled fetch whose entry (index = address bits 9:3) is valid with a matching tag (bits 31:10) is acknowledged in the same cycle without any bus access. The word returned is selected by address bit 2.
- R4: An enabled miss reads the four halfwords of the line in ascending order from the line base and overwrites the entry's data and tag. The word is acknowledged one cycle after the last read. Memory halfwords are little-endian, so a word is {halfword at a+2, halfword at a}.
- R5: Each 16-bit bus access lasts one cycle with `ws_en` low and two cycles with `ws_en` high, with address and data held steady. A miss therefore acknowledges 5 or 9 cycles after the request.
- R6: Misses always replace. After 2 KB of sequential fetches, the most recent 1 KB hits and the first 1 KB misses.
- R7: While disabled, a fetch reads the low then the high halfword of the word directly from memory and acknowledges one cycle later (3 or 5 cycles). The array is left unchanged.
- R8: A clear invalidates all 128 entries at one per cycle. `f_ack` stays low during the pass, so a fetch raised right after the write is delayed by 128 cycles.
- R9: A dump writes 6 halfwords per entry with a 12-byte stride from the base, in ascending entry order. The halfwords are the tag word low half, the tag word high half, then data halfwords 0 to 3. The tag word has bit 31 = valid and bits 21:0 = tag. Fetches stall until the last write, which takes 768 bus cycles at one cycle per access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ws_en | input | 1 | Wait states on: every bus access takes two cycles |
| f_req | input | 1 | Fetch request, held until acknowledged |
| f_waddr | input | ADDR_W-2 | Fetch word address (byte address bits 31:2) |
| f_ack | output | 1 | Fetch acknowledge, one cycle |
| f_rdata | output | 32 | Fetched word, valid with f_ack |
| cw_we | input | 1 | Control word write strobe |
| cw_data | input | ADDR_W | Control word: bit0 clear, bit1 enable, bit4 dump, 31:8 dump base |
| m_req | output | 1 | Bus access active |
| m_we | output | 1 | Bus access is a write (dump) |
| m_addr | output | ADDR_W | Bus byte address of the halfword |
| m_wdata | output | 16 | Bus write data |
| m_rdata | input | 16 | Bus read data, valid in the last cycle of an access |

## Verification
The reference model in the bench predicts, for every fetch, whether it hits, misses or bypasses, and so the exact acknowledge cycle.

A cache that filled once and then stayed saturated would be caught by the 2 KB stream: the later lines would keep missing. A design that touched the array while disabled would be caught too, because a line loaded before a bypass would no longer hit after the cache is re-enabled.

The dump image is compared entry by entry. A wrong stride, halfword order or valid-bit position shows up as a mismatched word. A write with both clear and dump set must produce no bus writes at all. Clear and dump stalls are checked to the cycle, so an early acknowledge or a wrong pass length is reported.

// File: rtl/fetch_cache_pkg.sv
package fetch_cache_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_BYPASS,
        ST_REPLY,
        ST_WIPE,
        ST_DUMP
    } fc_state_e;

    localparam int CW_CLEAR_BIT = 0;
    localparam int CW_EN_BIT    = 1;
    localparam int CW_DUMP_BIT  = 4;
    localparam int CW_BASE_LSB  = 8;
endpackage

// File: rtl/fc_bus_pacer.sv
module fc_bus_pacer #(
    parameter int SLOW_EXTRA = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic slow,
    output logic done
);
    localparam int CNT_W = $clog2(SLOW_EXTRA + 1);

    logic [CNT_W-1:0] cnt_q;

    assign done = active && (!slow || cnt_q == CNT_W'(SLOW_EXTRA));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (active && !done) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end else begin
            cnt_q <= '0;
        end
    end
endmodule

// File: rtl/fc_line_store.sv
module fc_line_store #(
    parameter int LINES = 128,
    parameter int TAG_W = 22,
    parameter int HPL   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(LINES)-1:0] rd_idx,
    output logic                     rd_valid,
    output logic [TAG_W-1:0]         rd_tag,
    output logic [16*HPL-1:0]        rd_line,
    input  logic                     wr_en,
    input  logic [$clog2(LINES)-1:0] wr_idx,
    input  logic [$clog2(HPL)-1:0]   wr_hw,
    input  logic [15:0]              wr_data,
    input  logic                     wr_last,
    input  logic [TAG_W-1:0]         wr_tag,
    input  logic                     inv_en,
    input  logic [$clog2(LINES)-1:0] inv_idx,
    output logic [LINES-1:0]         valid_all
);
    localparam int HW_W   = $clog2(HPL);
    localparam int LINE_W = 16 * HPL;

    logic [LINES-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [LINE_W-1:0] data_q [LINES];

    assign rd_valid  = valid_q[rd_idx];
    assign rd_tag    = tag_q[rd_idx];
    assign rd_line   = data_q[rd_idx];
    assign valid_all = valid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            if (inv_en) valid_q[inv_idx] <= 1'b0;
            if (wr_en && wr_last) valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) data_q[wr_idx][{wr_hw, 4'b0000} +: 16] <= wr_data;
        if (wr_en && wr_last) tag_q[wr_idx] <= wr_tag;
    end

    logic unused_hw;
    assign unused_hw = ^HW_W'(0);
endmodule

// File: rtl/fetch_cache.sv
module fetch_cache
    import fetch_cache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINES      = 128,
    parameter int LINE_B     = 8,
    parameter int SLOW_EXTRA = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ws_en,
    input  logic              f_req,
    input  logic [ADDR_W-3:0] f_waddr,
    output logic              f_ack,
    output logic [31:0]       f_rdata,
    input  logic              cw_we,
    input  logic [ADDR_W-1:0] cw_data,
    output logic              m_req,
    output logic              m_we,
    output logic [ADDR_W-1:0] m_addr,
    output logic [15:0]       m_wdata,
    input  logic [15:0]       m_rdata
);
    localparam int OFF_W  = $clog2(LINE_B);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int HPL    = LINE_B / 2;
    localparam int HW_W   = $clog2(HPL);
    localparam int WS_W   = OFF_W - 2;
    localparam int ENT_HW = HPL + 2;
    localparam int ENT_B  = 2 * ENT_HW;
    localparam int HC_W   = $clog2(ENT_HW);
    localparam int BASE_W = ADDR_W - CW_BASE_LSB;

    fc_state_e         state_q, nstate;
    logic              en_q;
    logic [BASE_W-1:0] base_q;
    logic [IDX_W-1:0]  idx_q;
    logic [HC_W-1:0]   hw_q;
    logic [31:0]       hold_q;

    logic [IDX_W-1:0]  f_idx, rd_idx;
    logic [TAG_W-1:0]  f_tag, rd_tag;
    logic [WS_W-1:0]   wsel;
    logic              rd_valid, hit, acc_done;
    logic [16*HPL-1:0] rd_line;
    logic [LINES-1:0]  valid_all;
    logic [31:0]       tag_word;
    logic [HW_W-1:0]   line_hw;
    logic [ADDR_W-1:0] dump_addr;
    logic              fill_last, ent_last, idx_last;
    logic              unused_cw;

    assign f_idx    = f_waddr[WS_W +: IDX_W];
    assign f_tag    = f_waddr[ADDR_W-3 -: TAG_W];
    assign wsel     = f_waddr[WS_W-1:0];
    assign rd_idx   = (state_q == ST_DUMP) ? idx_q : f_idx;
    assign hit      = rd_valid && (rd_tag == f_tag);
    assign fill_last = (hw_q == HC_W'(HPL - 1));
    assign ent_last = (hw_q == HC_W'(ENT_HW - 1));
    assign idx_last = (idx_q == IDX_W'(LINES - 1));
    assign line_hw  = HW_W'(hw_q - HC_W'(2));
    assign dump_addr = {base_q, {CW_BASE_LSB{1'b0}}}
                     + (ADDR_W'(idx_q) * ADDR_W'(ENT_B))
                     + ADDR_W'({hw_q, 1'b0});
    assign unused_cw = ^{cw_data[7:5], cw_data[3:2]};

    fc_line_store #(.LINES(LINES), .TAG_W(TAG_W), .HPL(HPL)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rd_idx),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_line  (rd_line),
        .wr_en    ((state_q == ST_FILL) && acc_done),
        .wr_idx   (f_idx),
        .wr_hw    (hw_q[HW_W-1:0]),
        .wr_data  (m_rdata),
        .wr_last  (fill_last),
        .wr_tag   (f_tag),
        .inv_en   (state_q == ST_WIPE),
        .inv_idx  (idx_q),
        .valid_all(valid_all)
    );

    fc_bus_pacer #(.SLOW_EXTRA(SLOW_EXTRA)) u_pacer (
        .clk   (clk),
        .rst_n (rst_n),
        .active(m_req),
        .slow  (ws_en),
        .done  (acc_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= nstate;
    end

    always_comb begin
        nstate = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cw_we) begin
                    if (cw_data[CW_CLEAR_BIT])     nstate = ST_WIPE;
                    else if (cw_data[CW_DUMP_BIT]) nstate = ST_DUMP;
                end else if (f_req) begin
                    if (!en_q)     nstate = ST_BYPASS;
                    else if (!hit) nstate = ST_FILL;
                end
            end
            ST_FILL:   if (acc_done && fill_last) nstate = ST_REPLY;
            ST_BYPASS: if (acc_done && hw_q[0])   nstate = ST_REPLY;
            ST_REPLY:  nstate = ST_IDLE;
            ST_WIPE:   if (idx_last) nstate = ST_IDLE;
            ST_DUMP:   if (acc_done && ent_last && idx_last) nstate = ST_IDLE;
            default:   nstate = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            base_q <= '0;
            idx_q  <= '0;
            hw_q   <= '0;
            hold_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    hw_q  <= '0;
                    idx_q <= '0;
                    if (cw_we) begin
                        en_q   <= cw_data[CW_EN_BIT];
                        base_q <= cw_data[ADDR_W-1:CW_BASE_LSB];
                    end
                end
                ST_FILL: if (acc_done) hw_q <= hw_q + HC_W'(1);
                ST_BYPASS: begin
                    if (acc_done) begin
                        hw_q <= hw_q + HC_W'(1);
                        if (hw_q[0]) hold_q[31:16] <= m_rdata;
                        else         hold_q[15:0]  <= m_rdata;
                    end
                end
                ST_WIPE: idx_q <= idx_q + IDX_W'(1);
                ST_DUMP: begin
                    if (acc_done) begin
                        if (ent_last) begin
                            hw_q  <= '0;
                            idx_q <= idx_q + IDX_W'(1);
                        end else begin
                            hw_q <= hw_q + HC_W'(1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        tag_word              = '0;
        tag_word[TAG_W-1:0]   = rd_tag;
        tag_word[31]          = rd_valid;
    end

    always_comb begin
        m_req   = 1'b0;
        m_we    = 1'b0;
        m_addr  = '0;
        m_wdata = '0;
        f_ack   = 1'b0;
        f_rdata = rd_line[{wsel, 5'b00000} +: 32];
        unique case (state_q)
            ST_IDLE: f_ack = f_req && !cw_we && en_q && hit;
            ST_FILL: begin
                m_req  = 1'b1;
                m_addr = {f_waddr[ADDR_W-3:WS_W], hw_q[HW_W-1:0], 1'b0};
            end
            ST_BYPASS: begin
                m_req  = 1'b1;
                m_addr = {f_waddr, hw_q[0], 1'b0};
            end
            ST_REPLY: begin
                f_ack = 1'b1;
                if (!en_q) f_rdata = hold_q;
            end
            ST_WIPE: ;
            ST_DUMP: begin
                m_req  = 1'b1;
                m_we   = 1'b1;
                m_addr = dump_addr;
                if (hw_q == HC_W'(0))      m_wdata = tag_word[15:0];
                else if (hw_q == HC_W'(1)) m_wdata = tag_word[31:16];
                else                       m_wdata = rd_line[{line_hw, 4'b0000} +: 16];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fetch_cache_props.sv
module fetch_cache_props
    import fetch_cache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LINES  = 128
) (
    input logic              clk,
    input logic              rst_n,
    input fc_state_e         state,
    input logic              f_ack,
    input logic              m_req,
    input logic [ADDR_W-1:0] m_addr,
    input logic              acc_done,
    input logic              hit,
    input logic              en_q,
    input logic [LINES-1:0]  valid_all,
    input logic [ADDR_W-9:0] base_q
);
    p_stall_wipe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WIPE) |-> !f_ack);

    p_stall_dump_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DUMP) |-> !f_ack);

    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !m_req);

    p_addr_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !acc_done) |=> $stable(m_addr));

    p_wipe_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(state == ST_WIPE) |-> (valid_all == '0));

    p_dump_base_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_DUMP) |-> (m_addr == {base_q, 8'h00}));

    p_reply_hits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REPLY && en_q) |-> hit);
endmodule

bind fetch_cache fetch_cache_props #(.ADDR_W(ADDR_W), .LINES(LINES)) u_props (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state_q),
    .f_ack    (f_ack),
    .m_req    (m_req),
    .m_addr   (m_addr),
    .acc_done (acc_done),
    .hit      (hit),
    .en_q     (en_q),
    .valid_all(valid_all),
    .base_q   (base_q)
);

// File: tb/sim_fetch_cache.sv
module sim_fetch_cache;
    localparam int PER   = 10;
    localparam int QP    = PER / 4;
    localparam int LINES = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ws = 1'b0;
    logic        f_req = 1'b0;
    logic [29:0] f_waddr = '0;
    logic        f_ack;
    logic [31:0] f_rdata;
    logic        cw_we = 1'b0;
    logic [31:0] cw_data = '0;
    logic        m_req, m_we;
    logic [31:0] m_addr;
    logic [15:0] m_wdata, m_rdata;

    int checks = 0;
    int errors = 0;
    int stall  = 0;
    int wcount = 0;
    bit          men = 1'b0;
    bit          mval [LINES];
    logic [21:0] mtag [LINES];
    bit          sval [LINES];
    logic [21:0] stag [LINES];
    logic [31:0] dbase = '0;
    logic [15:0] dmem [logic [31:0]];

    always #(PER/2) clk = ~clk;

    function automatic logic [15:0] pat(input logic [31:0] a);
        return a[16:1] ^ a[31:16] ^ 16'h5A3C;
    endfunction

    assign m_rdata = (m_req && !m_we) ? pat(m_addr) : 16'h0000;

    fetch_cache u0 (
        .clk(clk), .rst_n(rst_n), .ws_en(ws),
        .f_req(f_req), .f_waddr(f_waddr), .f_ack(f_ack), .f_rdata(f_rdata),
        .cw_we(cw_we), .cw_data(cw_data),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata)
    );

    always @(negedge clk) begin
        if (m_req && m_we) begin
            wcount++;
            dmem[m_addr] = m_wdata;
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic fetch(input logic [31:0] a, input string rq);
        int w, lat, ackk;
        logic [6:0]  ix;
        logic [21:0] tg;
        logic [31:0] wa, expd, dat;
        bit got;
        w  = ws ? 2 : 1;
        ix = a[9:3];
        tg = a[31:10];
        if (!men) lat = 2 * w + 1;
        else if (mval[ix] && mtag[ix] == tg) lat = 0;
        else begin
            lat = 4 * w + 1;
            mval[ix] = 1'b1;
            mtag[ix] = tg;
        end
        lat += stall;
        stall = 0;
        wa   = {a[31:2], 2'b00};
        expd = {pat(wa + 32'd2), pat(wa)};
        f_waddr = a[31:2];
        f_req   = 1'b1;
        got = 1'b0;
        ackk = -1;
        dat = '0;
        for (int k = 0; k <= lat + 2; k++) begin
            #(QP);
            if (f_ack) begin
                got = 1'b1;
                ackk = k;
                dat = f_rdata;
                break;
            end
            @(negedge clk);
        end
        if (got) @(negedge clk);
        f_req = 1'b0;
        chk(got && ackk == lat, rq, "ack cycle", ackk, lat);
        if (got) chk(dat == expd, rq, "fetch word", dat, expd);
    endtask

    task automatic cw(input logic [31:0] v);
        int w;
        w = ws ? 2 : 1;
        cw_data = v;
        cw_we   = 1'b1;
        @(negedge clk);
        cw_we = 1'b0;
        men = v[1];
        if (v[0]) begin
            for (int e = 0; e < LINES; e++) mval[e] = 1'b0;
            stall = LINES;
        end else if (v[4]) begin
            for (int e = 0; e < LINES; e++) begin
                sval[e] = mval[e];
                stag[e] = mtag[e];
            end
            dbase = {v[31:8], 8'h00};
            stall = 6 * LINES * w;
        end
    endtask

    task automatic check_dump();
        for (int e = 0; e < LINES; e++) begin
            logic [31:0] a0, line, tw, etw;
            bit ok;
            a0 = dbase + 32'(12 * e);
            ok = dmem.exists(a0) && dmem.exists(a0 + 2);
            tw = ok ? {dmem[a0 + 2], dmem[a0]} : 32'hFFFF_FFFF;
            if (sval[e]) begin
                etw  = {1'b1, 9'b0, stag[e]};
                line = {stag[e], 7'(e), 3'b000};
                ok = ok && (tw == etw);
                for (int k = 0; k < 4; k++) begin
                    logic [31:0] ha;
                    ha = a0 + 32'(4 + 2 * k);
                    ok = ok && dmem.exists(ha) && (dmem[ha] == pat(line + 32'(2 * k)));
                end
            end else begin
                etw = 32'h0;
                ok = ok && (tw[31] == 1'b0);
            end
            chk(ok, "R9", "dump entry", tw, etw);
        end
    endtask

    initial begin
        #(PER * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int e = 0; e < LINES; e++) begin
            mval[e] = 1'b0;
            mtag[e] = '0;
        end
        repeat (3) @(negedge clk);
        chk(f_ack == 1'b0, "R1", "ack in reset", 32'(f_ack), 0);
        chk(m_req == 1'b0, "R1", "bus in reset", 32'(m_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(f_ack == 1'b0 && m_req == 1'b0, "R1", "idle after reset",
            {f_ack, m_req}, 0);
        fetch(32'h0000_1000, "R1");

        cw(32'h0000_0003);
        fetch(32'h0000_1000, "R8");
        fetch(32'h0000_1000, "R3");
        fetch(32'h0000_1004, "R3");

        ws = 1'b1;
        fetch(32'h0000_2040, "R5");
        fetch(32'h0000_2044, "R5");

        cw(32'h0000_0000);
        fetch(32'h0000_1400, "R7");
        cw(32'h0000_0002);
        fetch(32'h0000_1000, "R7");
        fetch(32'h0000_1404, "R4");
        fetch(32'h0000_1000, "R4");

        ws = 1'b0;
        cw(32'h0000_0003);
        for (int i = 0; i < 512; i++) fetch(32'h0000_8000 + 32'(4 * i), "R6");
        for (int i = 0; i < 128; i++) fetch(32'h0000_8400 + 32'(8 * i), "R6");
        fetch(32'h0000_8000, "R6");

        ws = 1'b1;
        wcount = 0;
        cw(32'h0500_0012);
        fetch(32'h0000_8404, "R9");
        chk(wcount == 6 * LINES * 2, "R9", "dump write cycles", wcount, 6 * LINES * 2);
        check_dump();

        wcount = 0;
        cw(32'h0300_0013);
        fetch(32'h0000_8400, "R2");
        chk(wcount == 0, "R2", "writes on clear+dump", wcount, 0);
        chk(!dmem.exists(32'h0300_0000), "R2", "dump image present", 1, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule